// File: doc/BRIEF.md
# Crosspoint I/O Cell with Select Multiplexer and Configurable Storage

This block is one cell of a digital crosspoint switch. A four-way data multiplexer chooses one of four legs with a two-bit select. The select is decoded in Gray-code order. Each leg can be fuse-switched from its own direct routed input to the multiplexer output of a neighbouring cell. The legs are wired A to offset -2, B to -1, C to +1 and D to +2. Neighbouring cells can therefore be chained into wider multiplexers without passing through the routing fabric. The cell publishes its own multiplexer output so that neighbours can do the same.

A storage element sits behind the multiplexer. It works as an edge register or as a transparent latch, and a combinatorial-mode bit bypasses it. A path bit places it in one of two positions. On the output path it is fed from the multiplexer and drives the cell output. On the input path it is fed from the pad input and drives the fabric-side output. The storage clock and the storage enable each come from either a shared I/O line or a global line, and each has its own polarity bit. The cell output has a programmable polarity. All configuration bits are static inputs.

The effective storage clock is a data-rate signal sampled by the system clock `clk`. It must stay in each level for at least one `clk` cycle. Register-mode captures happen on its sampled rising edge.

Top module: `xpt_io_cell`

## Requirements
- R1: The select picks leg A (index 0) for `sel`=00, leg B (1) for 01, leg C (2) for 11 and leg D (3) for 10; `mux_out` follows combinationally.
- R2: When `exp_en[i]` is 1, leg i takes `exp_in[i]` in place of `direct_in[i]`; index 0..3 carries the neighbour at offset -2, -1, +1, +2. The fuse of a leg that is not selected has no effect on `mux_out`.
- R3: In register mode (`store_latch`=0), storage loads its data in the `clk` cycle where the effective clock is first seen high while enabled, and holds through the high phase, the low phase and any data change in between.
- R4: In latch mode (`store_latch`=1), storage loads its data on every `clk` edge while the effective clock and enable are both asserted, and holds while either is deasserted.
- R5: The effective clock is `io_clk` when `clk_sel_glb`=0 and `gclk` when 1, XORed with `clk_inv`; the unselected source has no effect.
- R6: The effective enable is `io_ce` when `ce_sel_glb`=0 and `gce` when 1, XORed with `ce_inv`; with it deasserted no load takes place.
- R7: With `path_in`=0 the storage is fed from `mux_out` and drives `cell_out`, while `grp_out` equals `pad_in`.
- R8: With `path_in`=1 the storage is fed from `pad_in` and drives `grp_out`, while `cell_out` follows `mux_out` combinationally.
- R9: With `comb_mode`=1 the storage is bypassed: on path A `cell_out` follows `mux_out`, and on path B `grp_out` follows `pad_in`.
- R10: `out_inv`=1 inverts `cell_out` only; `grp_out` is never inverted.
- R11: A low `rst_n` at a `clk` edge clears the storage to 0 ahead of the polarity inversion, so `cell_out` then shows `out_inv` on path A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the storage clock and enable |
| rst_n | input | 1 | Synchronous active-low reset of the storage |
| sel | input | 2 | Gray-coded leg select |
| direct_in | input | 4*DATA_W | Direct routed legs A..D |
| exp_in | input | 4*DATA_W | Neighbour multiplexer outputs at offsets -2, -1, +1, +2 |
| exp_en | input | 4 | Per-leg fuse: 1 takes the neighbour input |
| pad_in | input | DATA_W | Pad-side input data |
| io_clk | input | 1 | Shared I/O clock line |
| gclk | input | 1 | Dedicated global clock |
| clk_sel_glb | input | 1 | Clock source: 0 shared line, 1 global |
| clk_inv | input | 1 | Clock polarity invert |
| io_ce | input | 1 | Shared I/O enable line |
| gce | input | 1 | Global enable |
| ce_sel_glb | input | 1 | Enable source: 0 shared line, 1 global |
| ce_inv | input | 1 | Enable polarity invert |
| store_latch | input | 1 | Storage kind: 0 register, 1 latch |
| path_in | input | 1 | Storage position: 0 output path (A), 1 input path (B) |
| comb_mode | input | 1 | Bypass the storage |
| out_inv | input | 1 | Cell output polarity invert |
| mux_out | output | DATA_W | This cell's multiplexer output, for neighbours |
| cell_out | output | DATA_W | Cell output toward the pad |
| grp_out | output | DATA_W | Output toward the routing fabric |

## Verification
The hardest situations to reach are those where two independent settings must line up. One is an effective clock edge made by a polarity flip rather than by a line toggling. Another is an edge on the unselected clock or enable source, which has to be shown to do nothing. The bench handles these by reconfiguring while the raw line is parked at the level that keeps the effective clock low. It then waits a cycle so the sampled clock history settles, and only then moves the line that should or should not cause a load. Leg selection is covered by a vector table. Some entries place a 1 on the leg a binary decode would pick and a 0 on the Gray-decoded leg, and some set fuses only on legs that are not selected.

// File: rtl/xpt_cell_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and helpers for the crosspoint I/O cell.
// Assumes a fixed four-leg multiplexer with a two-bit select.
package xpt_cell_pkg;
    localparam int SEL_W  = 2;
    localparam int N_LEGS = 1 << SEL_W;

    // Gray-coded select to leg index: 00->0, 01->1, 11->2, 10->3.
    function automatic logic [SEL_W-1:0] gray_to_leg(input logic [SEL_W-1:0] g);
        logic [SEL_W-1:0] b;
        b[SEL_W-1] = g[SEL_W-1];
        for (int k = SEL_W - 2; k >= 0; k--) begin
            b[k] = b[k+1] ^ g[k];
        end
        return b;
    endfunction
endpackage

// File: rtl/xpt_leg_fuse.sv
`timescale 1ns/1ps
// Module: per-leg fuse selection between a direct input and a neighbour
// multiplexer output. Assumes fuses are static configuration.
module xpt_leg_fuse
    import xpt_cell_pkg::*;
#(
    parameter int DATA_W = 1
) (
    input  logic [N_LEGS*DATA_W-1:0] direct_in,
    input  logic [N_LEGS*DATA_W-1:0] exp_in,
    input  logic [N_LEGS-1:0]        exp_en,
    output logic [N_LEGS*DATA_W-1:0] leg_out
);
    for (genvar i = 0; i < N_LEGS; i++) begin : g_leg
        // Pick the neighbour input for this leg when its fuse is set.
        always_comb begin
            leg_out[i*DATA_W +: DATA_W] = exp_en[i] ? exp_in[i*DATA_W +: DATA_W]
                                                    : direct_in[i*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/xpt_gray_mux.sv
`timescale 1ns/1ps
// Module: four-way data multiplexer with Gray-coded select.
// Assumes legs are packed with leg 0 in the low slice.
module xpt_gray_mux
    import xpt_cell_pkg::*;
#(
    parameter int DATA_W = 1
) (
    input  logic [SEL_W-1:0]         sel,
    input  logic [N_LEGS*DATA_W-1:0] legs,
    output logic [DATA_W-1:0]        y
);
    logic [SEL_W-1:0] leg_idx;

    // Translate the Gray select to a leg index.
    always_comb leg_idx = gray_to_leg(sel);

    // Route the chosen leg to the output.
    always_comb y = legs[leg_idx*DATA_W +: DATA_W];
endmodule

// File: rtl/xpt_ctl_route.sv
`timescale 1ns/1ps
// Module: source and polarity selection for the storage clock and enable.
// Assumes all select and polarity bits are static.
module xpt_ctl_route (
    input  logic io_clk,
    input  logic gclk,
    input  logic clk_sel_glb,
    input  logic clk_inv,
    input  logic io_ce,
    input  logic gce,
    input  logic ce_sel_glb,
    input  logic ce_inv,
    output logic eff_clk,
    output logic eff_ce
);
    // Effective clock: chosen source, then polarity.
    always_comb eff_clk = (clk_sel_glb ? gclk : io_clk) ^ clk_inv;

    // Effective enable: chosen source, then polarity.
    always_comb eff_ce = (ce_sel_glb ? gce : io_ce) ^ ce_inv;
endmodule

// File: rtl/xpt_store.sv
`timescale 1ns/1ps
// Module: storage element acting as an edge register or a transparent
// latch. The effective clock is sampled by clk; it must hold each level
// for at least one clk cycle. Reset is synchronous, active low.
module xpt_store #(
    parameter int DATA_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_mode,
    input  logic              eff_clk,
    input  logic              eff_ce,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    logic eclk_q;
    logic rise;
    logic load;

    // Detect the sampled rising edge of the effective clock.
    always_comb rise = eff_clk & ~eclk_q;

    // Load when enabled: on the edge in register mode, on the level as a latch.
    always_comb load = eff_ce & (latch_mode ? eff_clk : rise);

    // Hold the clock history and the stored data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eclk_q <= 1'b0;
            q      <= '0;
        end else begin
            eclk_q <= eff_clk;
            if (load) q <= d;
        end
    end

    // R3: without a fresh edge the register keeps its value.
    p_reg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_mode && !(eff_clk && !eclk_q)) |=> $stable(q));

    // R4: an open, enabled latch passes the data one clk later.
    p_latch_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_mode && eff_clk && eff_ce) |=> (q == $past(d)));

    // R6: a deasserted enable blocks every load.
    p_ce_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!eff_ce) |=> $stable(q));

    // R11: reset clears the storage.
    p_reset_clear_r11: assert property (@(posedge clk)
        (!rst_n) |=> (q == '0));
endmodule

// File: rtl/xpt_io_cell.sv
`timescale 1ns/1ps
// Module: top of one crosspoint I/O cell. Fused legs feed a Gray-select
// multiplexer; a storage element sits on the output path (A) or the input
// path (B), or is bypassed; the cell output has programmable polarity.
// Assumes configuration inputs are static during operation.
module xpt_io_cell
    import xpt_cell_pkg::*;
#(
    parameter int DATA_W = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SEL_W-1:0]         sel,
    input  logic [N_LEGS*DATA_W-1:0] direct_in,
    input  logic [N_LEGS*DATA_W-1:0] exp_in,
    input  logic [N_LEGS-1:0]        exp_en,
    input  logic [DATA_W-1:0]        pad_in,
    input  logic                     io_clk,
    input  logic                     gclk,
    input  logic                     clk_sel_glb,
    input  logic                     clk_inv,
    input  logic                     io_ce,
    input  logic                     gce,
    input  logic                     ce_sel_glb,
    input  logic                     ce_inv,
    input  logic                     store_latch,
    input  logic                     path_in,
    input  logic                     comb_mode,
    input  logic                     out_inv,
    output logic [DATA_W-1:0]        mux_out,
    output logic [DATA_W-1:0]        cell_out,
    output logic [DATA_W-1:0]        grp_out
);
    logic [N_LEGS*DATA_W-1:0] legs;
    logic                     eff_clk;
    logic                     eff_ce;
    logic [DATA_W-1:0]        store_d;
    logic [DATA_W-1:0]        store_q;
    logic [DATA_W-1:0]        cell_pre;

    xpt_leg_fuse #(.DATA_W(DATA_W)) u_fuse (
        .direct_in (direct_in),
        .exp_in    (exp_in),
        .exp_en    (exp_en),
        .leg_out   (legs)
    );

    xpt_gray_mux #(.DATA_W(DATA_W)) u_mux (
        .sel  (sel),
        .legs (legs),
        .y    (mux_out)
    );

    xpt_ctl_route u_ctl (
        .io_clk      (io_clk),
        .gclk        (gclk),
        .clk_sel_glb (clk_sel_glb),
        .clk_inv     (clk_inv),
        .io_ce       (io_ce),
        .gce         (gce),
        .ce_sel_glb  (ce_sel_glb),
        .ce_inv      (ce_inv),
        .eff_clk     (eff_clk),
        .eff_ce      (eff_ce)
    );

    // Feed the storage from the multiplexer on path A, from the pad on path B.
    always_comb store_d = path_in ? pad_in : mux_out;

    xpt_store #(.DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .latch_mode (store_latch),
        .eff_clk    (eff_clk),
        .eff_ce     (eff_ce),
        .d          (store_d),
        .q          (store_q)
    );

    // Pad-side value before polarity: storage only on path A without bypass.
    always_comb cell_pre = (!path_in && !comb_mode) ? store_q : mux_out;

    // Apply the output polarity.
    always_comb cell_out = cell_pre ^ {DATA_W{out_inv}};

    // Fabric-side value: storage only on path B without bypass.
    always_comb grp_out = (path_in && !comb_mode) ? store_q : pad_in;

    // R1: select 11 with no fuses shows direct leg C, not leg D.
    p_gray_leg_c_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b11 && exp_en == '0) |-> (mux_out == direct_in[2*DATA_W +: DATA_W]));

    // R2: a fused leg A shows the neighbour at offset -2.
    p_fuse_leg_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b00 && exp_en[0]) |-> (mux_out == exp_in[0 +: DATA_W]));

    // R7: on path A the fabric side sees the pad directly.
    p_grp_pad_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!path_in) |-> (grp_out == pad_in));

    // R8: on path B the cell output follows the multiplexer.
    p_pathb_cell_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (path_in) |-> (cell_out == (mux_out ^ {DATA_W{out_inv}})));

    // R9: bypass on path A bypasses the storage.
    p_comb_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (comb_mode && !path_in) |-> (cell_out == (mux_out ^ {DATA_W{out_inv}})));
endmodule

// File: tb/xpt_io_cell_tb_top.sv
`timescale 1ns/1ps
// Bench: table-driven multiplexer checks, then directed storage tests.
module xpt_io_cell_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = '0;
    logic [3:0] direct_in = '0;
    logic [3:0] exp_in = '0;
    logic [3:0] exp_en = '0;
    logic       pad_in = 1'b0;
    logic       io_clk = 1'b0, gclk = 1'b0, clk_sel_glb = 1'b0, clk_inv = 1'b0;
    logic       io_ce = 1'b1, gce = 1'b0, ce_sel_glb = 1'b0, ce_inv = 1'b0;
    logic       store_latch = 1'b0, path_in = 1'b0, comb_mode = 1'b0, out_inv = 1'b0;
    logic       mux_out, cell_out, grp_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    xpt_io_cell #(.DATA_W(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .sel(sel), .direct_in(direct_in),
        .exp_in(exp_in), .exp_en(exp_en), .pad_in(pad_in),
        .io_clk(io_clk), .gclk(gclk), .clk_sel_glb(clk_sel_glb), .clk_inv(clk_inv),
        .io_ce(io_ce), .gce(gce), .ce_sel_glb(ce_sel_glb), .ce_inv(ce_inv),
        .store_latch(store_latch), .path_in(path_in), .comb_mode(comb_mode),
        .out_inv(out_inv), .mux_out(mux_out), .cell_out(cell_out), .grp_out(grp_out)
    );

    // Fields: [15:14] sel, [13:10] exp_en, [9:6] direct, [5:2] exp, [1] out_inv, [0] mux.
    localparam logic [15:0] VEC [12] = '{
        16'b00_0000_0001_0000_0_1,
        16'b01_0000_0010_0000_0_1,
        16'b11_0000_0100_0000_0_1,
        16'b10_0000_1000_0000_0_1,
        16'b11_0000_1000_0000_0_0,
        16'b10_0000_0100_0000_0_0,
        16'b00_0001_0001_0000_0_0,
        16'b01_0010_0000_0010_0_1,
        16'b11_0100_0100_1011_0_0,
        16'b10_1000_0000_1000_1_1,
        16'b10_0111_1000_0111_0_1,
        16'b00_1110_0000_1110_1_0
    };

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance n clk edges, then settle at the falling edge.
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R11: reset state, before and after inversion.
        direct_in = 4'b1111;
        tick(2);
        check("R11 reset clears cell_out", cell_out, 1'b0);
        out_inv = 1'b1; #1;
        check("R11 R10 reset seen inverted", cell_out, 1'b1);
        out_inv = 1'b0;
        rst_n = 1'b1;
        tick(1);
        check("R3 no edge after reset", cell_out, 1'b0);

        // R3: register captures on rising effective clock, holds otherwise.
        io_clk = 1'b1; tick(1);
        check("R3 capture on rise", cell_out, 1'b1);
        direct_in = 4'b0000; tick(2);
        check("R3 hold while clock high", cell_out, 1'b1);
        io_clk = 1'b0; tick(1);
        check("R3 hold on fall", cell_out, 1'b1);
        io_clk = 1'b1; tick(1);
        check("R3 capture second rise", cell_out, 1'b0);
        io_clk = 1'b0; tick(1);

        // R6: enable blocks, inverted enable admits.
        direct_in = 4'b1111; io_ce = 1'b0;
        io_clk = 1'b1; tick(1);
        check("R6 enable off blocks load", cell_out, 1'b0);
        io_clk = 1'b0; ce_inv = 1'b1; tick(1);
        io_clk = 1'b1; tick(1);
        check("R6 inverted enable loads", cell_out, 1'b1);
        io_clk = 1'b0; ce_inv = 1'b0; io_ce = 1'b1; tick(1);

        // R6: global enable source ignores the shared line.
        ce_sel_glb = 1'b1; gce = 1'b0; direct_in = 4'b0000;
        io_clk = 1'b1; tick(1);
        check("R6 global enable low blocks", cell_out, 1'b1);
        io_clk = 1'b0; gce = 1'b1; tick(1);
        io_clk = 1'b1; tick(1);
        check("R6 global enable high loads", cell_out, 1'b0);
        io_clk = 1'b0; ce_sel_glb = 1'b0; tick(1);

        // R5: clock polarity makes the falling line the active edge.
        io_clk = 1'b1; clk_inv = 1'b1; tick(2);
        direct_in = 4'b1111; tick(1);
        check("R5 inverted clock no edge yet", cell_out, 1'b0);
        io_clk = 1'b0; tick(1);
        check("R5 inverted clock loads on fall", cell_out, 1'b1);
        io_clk = 1'b1; tick(1);
        clk_inv = 1'b0; tick(1);
        io_clk = 1'b0; tick(2);

        // R5: global clock source ignores the shared line.
        clk_sel_glb = 1'b1; direct_in = 4'b0000;
        io_clk = 1'b1; tick(1);
        check("R5 shared clock ignored", cell_out, 1'b1);
        io_clk = 1'b0; tick(1);
        gclk = 1'b1; tick(1);
        check("R5 global clock loads", cell_out, 1'b0);
        gclk = 1'b0; clk_sel_glb = 1'b0; tick(1);

        // R10: polarity on the registered value.
        out_inv = 1'b1; #1;
        check("R10 inverted stored zero", cell_out, 1'b1);
        out_inv = 1'b0;

        // R4: latch transparency and hold.
        store_latch = 1'b1; io_clk = 1'b1; direct_in = 4'b1111; tick(1);
        check("R4 latch open passes 1", cell_out, 1'b1);
        direct_in = 4'b0000; tick(1);
        check("R4 latch open passes 0", cell_out, 1'b0);
        io_clk = 1'b0; direct_in = 4'b1111; tick(2);
        check("R4 latch closed holds", cell_out, 1'b0);
        io_clk = 1'b1; tick(1);
        check("R4 latch reopens", cell_out, 1'b1);
        io_ce = 1'b0; direct_in = 4'b0000; tick(1);
        check("R4 R6 open latch disabled holds", cell_out, 1'b1);
        io_ce = 1'b1; io_clk = 1'b0; store_latch = 1'b0; tick(1);

        // R7: fabric side sees the pad on path A.
        pad_in = 1'b1; #1;
        check("R7 grp_out follows pad 1", grp_out, 1'b1);
        pad_in = 1'b0; #1;
        check("R7 grp_out follows pad 0", grp_out, 1'b0);

        // R8: storage on the input path.
        path_in = 1'b1; direct_in = 4'b0000; #1;
        check("R8 cell_out follows mux 0", cell_out, 1'b0);
        direct_in = 4'b1111; #1;
        check("R8 cell_out follows mux 1", cell_out, 1'b1);
        check("R8 grp_out shows storage", grp_out, 1'b1);
        io_clk = 1'b1; tick(1);
        check("R8 pad captured to grp_out", grp_out, 1'b0);
        check("R8 cell_out still mux", cell_out, 1'b1);
        io_clk = 1'b0; tick(1);
        pad_in = 1'b1; tick(2);
        check("R8 grp_out holds without edge", grp_out, 1'b0);
        out_inv = 1'b1; #1;
        check("R10 cell_out inverted on path B", cell_out, 1'b0);
        check("R10 grp_out not inverted", grp_out, 1'b0);
        out_inv = 1'b0;

        // R9: bypass on path B.
        comb_mode = 1'b1; #1;
        check("R9 path B bypass shows pad", grp_out, 1'b1);
        pad_in = 1'b0; #1;
        check("R9 path B bypass follows pad", grp_out, 1'b0);

        // R1 R2 R9 R10: vector table on path A with bypass.
        path_in = 1'b0;
        for (int i = 0; i < 12; i++) begin
            sel = VEC[i][15:14];
            exp_en = VEC[i][13:10];
            direct_in = VEC[i][9:6];
            exp_in = VEC[i][5:2];
            out_inv = VEC[i][1];
            tick(1);
            check($sformatf("R1 R2 vector %0d mux_out", i), mux_out, VEC[i][0]);
            check($sformatf("R9 R10 vector %0d cell_out", i), cell_out, VEC[i][0] ^ VEC[i][1]);
        end

        // R11: reset in mid-run clears a loaded 1.
        comb_mode = 1'b0; out_inv = 1'b0; sel = 2'b00; exp_en = 4'b0000;
        direct_in = 4'b1111; tick(1);
        io_clk = 1'b1; tick(1);
        check("R3 load before reset", cell_out, 1'b1);
        rst_n = 1'b0; tick(1);
        check("R11 mid-run reset clears", cell_out, 1'b0);
        rst_n = 1'b1; io_clk = 1'b0; tick(1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule